// File: doc/BRIEF.md
# Object Field Cache

This block caches the fields of objects, with each entry keyed by an object reference and a field number, not by a physical address. A client presents a 32-bit reference and a 32-bit field index on a valid/ready request channel. A read that finds its field in the cache returns the word one clock later. A read that misses holds the request off while a refill engine loads the whole line from a word-read memory port. The refill uses the reference as a byte address of the object, so the target field sits at reference + 4 × index.

A line holds four consecutive fields. The four fields start at an index that is a multiple of four. The cache is direct-mapped over 64 lines. The line is picked by XORing the six low bits of the reference with index bits 7..2. Stores go straight through to memory. A store that hits also updates the cached word. A store that misses leaves the cache untouched. A single-cycle flush input drops every line.

Top module: `field_cache`

## Requirements
- R1: A read whose line is cached is accepted (reqReady high) in the cycle it is presented. rspValid is high the next cycle, and rspData holds the memory word at reqRef + 4*reqIdx.
- R2: A read that misses keeps reqReady low for exactly 5 cycles. It is accepted in the 6th cycle, which is the cycle after the last fill word is written. Its data follows one cycle later, as in R1.
- R3: A refill issues exactly four memRdEn reads, one per cycle, in ascending order. The addresses are B, B+4, B+8 and B+12, where B = reqRef + 4*(reqIdx with bits 1..0 cleared). memRdata is taken in the cycle after each memRdEn.
- R4: Once a line has been filled, reads of any of its four fields hit, with no stall and no memory read.
- R5: The line slot is reqRef[5:0] XOR reqIdx[7:2]. An entry matches only on the full reference and on reqIdx[31:2]. A different key that maps to the same slot evicts the entry.
- R6: A store (reqWrite=1) is accepted in the cycle it is presented. In that cycle it drives memWrEn with memAddr = reqRef + 4*reqIdx and memWdata = reqWdata. No rspValid follows.
- R7: A store that hits updates the cached word, so a later read hits and returns the stored data.
- R8: A store that misses allocates nothing, so a later read of that field misses and refills.
- R9: In a cycle where flushAll is high, no request is accepted. After that cycle every line is invalid, so a key that was cached misses.
- R10: After reset, rspValid, memRdEn and memWrEn are low and no line is valid.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Invalidate every line this cycle |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqRef | input | 32 | Object reference (byte address of the object) |
| reqIdx | input | 32 | Field index |
| reqWdata | input | 32 | Store data |
| rspValid | output | 1 | Load data valid |
| rspData | output | 32 | Load data |
| memRdEn | output | 1 | Memory word read strobe |
| memWrEn | output | 1 | Memory word write strobe |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Read data, valid the cycle after memRdEn |

## Verification
A hit is checked at reqReady in the presentation cycle and at rspValid/rspData exactly one cycle after acceptance. A miss is checked by counting the cycles reqReady stays low: 5 are expected. The refill addresses are logged from the memory port and compared with the four expected addresses in order. A store's memory write is checked in the cycle it is accepted, and the bench confirms that no response follows one cycle later. All inputs are driven and all outputs sampled on the falling edge, so each expected value is read in the cycle its register has already updated.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef struct packed {
    logic capture;   // latch request key for a refill
    logic fillWr;    // write returning memory word into the line
    logic tagSet;    // install tag and valid bit for the filled line
    logic memRd;     // issue a memory word read
    logic memWr;     // write-through store
    logic rspLoad;   // register load data for the response
    logic storeHit;  // update cached word on a store hit
    logic fromReq;   // memory read address comes from live request
  } fcStrobes_t;
endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushAll,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             hit,
  output logic             reqReady,
  output fcStrobes_t       ctl,
  output logic [OFF_W-1:0] issueOff,
  output logic [OFF_W-1:0] fillOff
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  typedef enum logic {ST_IDLE, ST_FILL} fcState_t;
  fcState_t state;
  logic [OFF_W-1:0] fillCnt;
  logic idle, accept, startFill, lastWord;

  always_comb begin
    idle      = (state == ST_IDLE);
    lastWord  = (fillCnt == LAST);
    reqReady  = idle && !flushAll && (reqWrite || hit);
    accept    = reqValid && reqReady;
    startFill = idle && !flushAll && reqValid && !reqWrite && !hit;
    ctl.capture  = startFill;
    ctl.fromReq  = idle;
    ctl.fillWr   = (state == ST_FILL);
    ctl.tagSet   = (state == ST_FILL) && lastWord;
    ctl.memRd    = startFill || ((state == ST_FILL) && !lastWord);
    ctl.memWr    = accept && reqWrite;
    ctl.rspLoad  = accept && !reqWrite;
    ctl.storeHit = accept && reqWrite && hit;
    issueOff = idle ? '0 : fillCnt + 1'b1;
    fillOff  = fillCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startFill) begin
          state   <= ST_FILL;
          fillCnt <= '0;
        end
        ST_FILL: begin
          fillCnt <= fillCnt + 1'b1;
          if (lastWord) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the requester sees no ready while a refill is running
  assert_no_ready_in_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> !reqReady);
  // R3: each fill write consumes a read issued one cycle before
  assert_fill_follows_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWr |-> $past(ctl.memRd));
  // R6: the memory port never reads and writes together
  assert_port_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.memRd && ctl.memWr));
  // R9: flush blocks acceptance
  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !reqReady);
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_COUNT = 64,
  parameter int LINE_WORDS = 4,
  localparam int SET_W  = $clog2(LINE_COUNT),
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int TIDX_W = ADDR_W - OFF_W,
  localparam int SLOT_W = SET_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  fcStrobes_t        ctl,
  input  logic [OFF_W-1:0]  issueOff,
  input  logic [OFF_W-1:0]  fillOff,
  input  logic [ADDR_W-1:0] reqRef,
  input  logic [ADDR_W-1:0] reqIdx,
  input  logic [ADDR_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              hit,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata
);
  logic [ADDR_W-1:0] dataArr [LINE_COUNT*LINE_WORDS];
  logic [ADDR_W-1:0] tagRef  [LINE_COUNT];
  logic [TIDX_W-1:0] tagIdx  [LINE_COUNT];
  logic [LINE_COUNT-1:0] validBits;

  logic [SET_W-1:0]  reqSet, fillSet;
  logic [OFF_W-1:0]  reqOff;
  logic [ADDR_W-1:0] lineIdx, reqBase, fieldAddr, fillBase;
  logic [ADDR_W-1:0] fillRef;
  logic [TIDX_W-1:0] fillIdxHi;

  always_comb begin
    reqSet    = reqRef[SET_W-1:0] ^ reqIdx[OFF_W +: SET_W];
    reqOff    = reqIdx[OFF_W-1:0];
    hit       = validBits[reqSet] && (tagRef[reqSet] == reqRef)
                && (tagIdx[reqSet] == reqIdx[ADDR_W-1:OFF_W]);
    lineIdx   = {reqIdx[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    reqBase   = reqRef + (lineIdx << 2);
    fieldAddr = reqRef + (reqIdx << 2);
    if (ctl.memWr)        memAddr = fieldAddr;
    else if (ctl.fromReq) memAddr = reqBase;
    else                  memAddr = fillBase + (ADDR_W'(issueOff) << 2);
    memWdata = reqWdata;
  end

  always_ff @(posedge clk) begin
    if (ctl.capture) begin
      fillSet   <= reqSet;
      fillBase  <= reqBase;
      fillRef   <= reqRef;
      fillIdxHi <= reqIdx[ADDR_W-1:OFF_W];
    end
    if (ctl.fillWr)   dataArr[SLOT_W'({fillSet, fillOff})] <= memRdata;
    if (ctl.storeHit) dataArr[SLOT_W'({reqSet, reqOff})]   <= reqWdata;
    if (ctl.tagSet) begin
      tagRef[fillSet] <= fillRef;
      tagIdx[fillSet] <= fillIdxHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else begin
      if (flushAll) validBits <= '0;
      if (ctl.tagSet) validBits[fillSet] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= ctl.rspLoad;
      if (ctl.rspLoad) rspData <= dataArr[SLOT_W'({reqSet, reqOff})];
    end
  end

  // R1: a read is only accepted when the tag lookup matched
  assert_read_needs_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rspLoad |-> hit);
  // R9: a flush with no concurrent install leaves no valid line
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll && !ctl.tagSet) |=> (validBits == '0));
  // R7: a store update and a fill write never collide
  assert_no_write_clash_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.fillWr && ctl.storeHit));
endmodule

// File: rtl/field_cache.sv
module field_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_COUNT = 64,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqRef,
  input  logic [ADDR_W-1:0] reqIdx,
  input  logic [ADDR_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspData,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  fcStrobes_t       ctl;
  logic             hit;
  logic [OFF_W-1:0] issueOff, fillOff;

  fc_ctrl #(.LINE_WORDS(LINE_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqWrite(reqWrite), .hit(hit), .reqReady(reqReady), .ctl(ctl),
    .issueOff(issueOff), .fillOff(fillOff)
  );

  fc_datapath #(.ADDR_W(ADDR_W), .LINE_COUNT(LINE_COUNT), .LINE_WORDS(LINE_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .ctl(ctl),
    .issueOff(issueOff), .fillOff(fillOff), .reqRef(reqRef), .reqIdx(reqIdx),
    .reqWdata(reqWdata), .memRdata(memRdata), .hit(hit), .rspValid(rspValid),
    .rspData(rspData), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memRdEn = ctl.memRd;
  assign memWrEn = ctl.memWr;

  // R1: a response only ever follows an accepted load
  assert_rsp_after_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && !reqWrite));
  // R6: a store never produces a response
  assert_store_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && reqReady && reqWrite) |-> !rspValid);
endmodule

// File: tb/test_field_cache.sv
module test_field_cache;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, flushAll, reqValid, reqReady, reqWrite;
  logic [31:0] reqRef, reqIdx, reqWdata, rspData, memAddr, memWdata, memRdata;
  logic rspValid, memRdEn, memWrEn;

  field_cache i_field_cache (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqRef(reqRef), .reqIdx(reqIdx),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  int compared = 0;
  int mismatched = 0;

  logic [31:0] memStore [logic [31:0]];
  logic [31:0] fillLog [$];

  bit          mVal [64];
  logic [31:0] mRef [64];
  logic [29:0] mIdx [64];

  function automatic logic [31:0] memInit(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h3C5A0F17;
  endfunction

  function automatic logic [31:0] memGet(input logic [31:0] a);
    if (memStore.exists(a)) return memStore[a];
    return memInit(a);
  endfunction

  function automatic int mSet(input logic [31:0] r, input logic [31:0] i);
    return int'(r[5:0] ^ i[7:2]);
  endfunction

  function automatic bit mHit(input logic [31:0] r, input logic [31:0] i);
    int s = mSet(r, i);
    return mVal[s] && mRef[s] == r && mIdx[s] == i[31:2];
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdata <= memGet(memAddr);
      fillLog.push_back(memAddr);
    end
    if (memWrEn) memStore[memAddr] = memWdata;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doRead(input logic [31:0] r, input logic [31:0] i, input string tag);
    bit expHit = mHit(r, i);
    logic [31:0] base = r + ((i & ~32'd3) << 2);
    int waits = 0;
    @(negedge clk);
    fillLog.delete();
    reqValid = 1'b1; reqWrite = 1'b0; reqRef = r; reqIdx = i;
    #1;
    while (!reqReady && waits < 20) begin
      @(negedge clk); #1; waits++;
    end
    if (expHit) check("R1", {tag, " hit stall"}, 32'(waits), 32'd0);
    else        check("R2", {tag, " miss stall"}, 32'(waits), 32'd5);
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    check("R1", {tag, " rspValid"}, {31'd0, rspValid}, 32'd1);
    check("R1", {tag, " rspData"}, rspData, memGet(r + (i << 2)));
    if (expHit) begin
      check("R4", {tag, " no refill on hit"}, 32'(fillLog.size()), 32'd0);
    end else begin
      check("R3", {tag, " refill reads"}, 32'(fillLog.size()), 32'd4);
      for (int k = 0; k < 4 && k < fillLog.size(); k++)
        check("R3", {tag, " refill addr"}, fillLog[k], base + 32'(4 * k));
      mVal[mSet(r, i)] = 1'b1;
      mRef[mSet(r, i)] = r;
      mIdx[mSet(r, i)] = i[31:2];
    end
  endtask

  task automatic doWrite(input logic [31:0] r, input logic [31:0] i,
                         input logic [31:0] d, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqRef = r; reqIdx = i; reqWdata = d;
    #1;
    check("R6", {tag, " store ready"}, {31'd0, reqReady}, 32'd1);
    check("R6", {tag, " memWrEn"}, {31'd0, memWrEn}, 32'd1);
    check("R6", {tag, " memAddr"}, memAddr, r + (i << 2));
    check("R6", {tag, " memWdata"}, memWdata, d);
    @(posedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
    check("R6", {tag, " no response"}, {31'd0, rspValid}, 32'd0);
  endtask

  task automatic doFlush(input logic [31:0] r, input logic [31:0] i);
    @(negedge clk);
    flushAll = 1'b1; reqValid = 1'b1; reqWrite = 1'b0; reqRef = r; reqIdx = i;
    #1;
    check("R9", "ready during flush", {31'd0, reqReady}, 32'd0);
    @(posedge clk); #1;
    flushAll = 1'b0; reqValid = 1'b0;
    for (int s = 0; s < 64; s++) mVal[s] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 64; s++) mVal[s] = 1'b0;
    rstN = 1'b0; flushAll = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqRef = '0; reqIdx = '0; reqWdata = '0; memRdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "rspValid after reset", {31'd0, rspValid}, 32'd0);
    check("R10", "memRdEn after reset", {31'd0, memRdEn}, 32'd0);
    check("R10", "memWrEn after reset", {31'd0, memWrEn}, 32'd0);

    doRead(32'h1000, 32'd3, "R10 first read misses");
    doRead(32'h1000, 32'd0, "R4 line word0");
    doRead(32'h1000, 32'd1, "R4 line word1");
    doRead(32'h1000, 32'd2, "R4 line word2");
    doRead(32'h1040, 32'd0, "R5 conflict ref");
    doRead(32'h1000, 32'd1, "R5 evicted");
    doRead(32'h1004, 32'd16, "R5 hashed slot");
    doRead(32'h1000, 32'd6, "R5 other slot");
    doRead(32'h1000, 32'd6, "R5 other slot hit");
    doRead(32'h1000, 32'd5, "R7 fill");
    doWrite(32'h1000, 32'd5, 32'hCAFE0001, "R7 store hit");
    doRead(32'h1000, 32'd5, "R7 read back");
    doWrite(32'h5000, 32'd9, 32'hBEEF0002, "R8 store miss");
    doRead(32'h5000, 32'd9, "R8 read misses");
    doFlush(32'h1000, 32'd5);
    doRead(32'h1000, 32'd5, "R9 after flush");
    doRead(32'hFFFFFFF8, 32'd5, "R11 wrapped refill");
    doWrite(32'hFFFFFFFC, 32'd2, 32'h12345678, "R11 wrapped store");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] pool [6] = '{32'h2000, 32'h2040, 32'h2004, 32'h3000, 32'hFFFFFFF0, 32'h2080};
      logic [31:0] r = pool[$urandom % 6];
      logic [31:0] i = 32'($urandom % 16);
      int op = $urandom % 100;
      if (op < 3)       doFlush(r, i);
      else if (op < 28) doWrite(r, i, $urandom, "R7 random store");
      else              doRead(r, i, "R1 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule